// File: doc/BRIEF.md
# Associative Search Array with Responder Stepping

This block holds a row of processing elements (PEs). Each PE keeps one 8-bit value, a responder flag and a four-entry mask stack. A control side sends one command per cycle. A search command carries a key and a comparison kind. Every enabled PE compares its own value with the key at the same moment, then records the outcome both as its responder flag and as a new entry pushed onto its mask stack. A PE is enabled when the top of its mask stack is 1. An empty stack counts as enabled.

A step command hands the responders over one at a time through a priority resolver. The resolver picks the responder with the lowest index and registers that index with a valid flag. It clears the chosen PE's responder flag and rewrites the top of every mask stack, so that only the chosen PE stays enabled. A pop command throws away the top entry of every mask stack, which restores the enabling that was in force before. A load port writes the value of one PE so the array can be filled.

Commands are sequenced by a small state machine whose state names the command being carried out. ST_IDLE follows a no-op, ST_SEARCH follows a search, ST_STEP follows a step and ST_POP follows a pop. Every cycle, the command on the input moves the machine to the matching state: NOP goes to ST_IDLE, SEARCH to ST_SEARCH, STEP to ST_STEP and POP to ST_POP. Any state can reach any other. In the cycle after the transition, the state drives that command's action into the array.

Top module: `assoc_search_array`

## Requirements
- R1: After reset, sel_valid is 0, sel_idx is 0, any_resp is 0, and every mask stack is empty, so every PE is enabled.
- R2: A search (cmd code 1) with cmp_sel 0 (equal) makes each enabled PE whose loaded value equals key a responder, and clears the flag of every other enabled PE. any_resp is the OR of all responder flags. Values are written through ld_en, ld_idx and ld_val.
- R3: cmp_sel 1 selects unsigned value < key and cmp_sel 2 selects unsigned value > key. cmp_sel 3 matches no PE.
- R4: A PE whose mask top is 0 ignores a search. Its responder flag and its stack stay unchanged.
- R5: A step (cmd code 2) sets sel_idx to the lowest index whose responder flag is set and raises sel_valid. This happens whether or not that PE is enabled.
- R6: A step clears the responder flag of the PE it chose, so successive steps visit responders in ascending index order. any_resp falls after the last one is taken.
- R7: A step made while no responder flag is set drives sel_valid low.
- R8: A step leaves the top of the mask stack at 1 for the chosen PE only and at 0 for every other PE. An empty stack receives the new top as its single entry.
- R9: A pop (cmd code 3) discards the top entry of every PE's mask stack, whether or not the PE is enabled. A pop on an empty stack has no effect.
- R10: A mask stack holds four entries. A push onto a full stack drops the oldest entry, and a pop exposes the entry beneath the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write ld_val into the PE chosen by ld_idx |
| ld_idx | input | $clog2(N) | PE index for a load |
| ld_val | input | W | Value to load |
| cmd | input | 2 | 0 no-op, 1 search, 2 step, 3 pop |
| cmp_sel | input | 2 | Comparison for search: 0 equal, 1 less, 2 greater, 3 none |
| key | input | W | Search key |
| sel_idx | output | $clog2(N) | Index chosen by the last step |
| sel_valid | output | 1 | The last step found a responder |
| any_resp | output | 1 | At least one responder flag is set |

## Verification
A command placed on the inputs before clock edge E0 is latched at E0 and acts on the array at E1. Responder flags, any_resp, sel_idx and sel_valid therefore all show its effect after E1, two edges after the command was applied. A load takes effect at the single edge where ld_en is sampled. The bench drives every input on a falling edge and holds cmd at no-op after one edge. It samples only on the falling edge that follows E1, so each check reads a settled value two edges after its command. Effects that cannot be seen directly, such as a disabled PE or a popped stack, are read out later with a search followed by steps.

// File: rtl/as_pkg.sv
package as_pkg;

    typedef enum logic [1:0] {
        CMD_NOP    = 2'd0,
        CMD_SEARCH = 2'd1,
        CMD_STEP   = 2'd2,
        CMD_POP    = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        CMP_EQ   = 2'd0,
        CMP_LT   = 2'd1,
        CMP_GT   = 2'd2,
        CMP_NONE = 2'd3
    } cmp_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_STEP   = 2'd2,
        ST_POP    = 2'd3
    } state_e;

endpackage

// File: rtl/as_pe.sv
module as_pe
    import as_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_we,
    input  logic [W-1:0] ld_val,
    input  logic         do_search,
    input  logic         do_step,
    input  logic         do_pop,
    input  logic [W-1:0] key,
    input  cmp_e         cmp,
    input  logic         is_sel,
    output logic         resp,
    output logic         top
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]     val_q;
    logic [DEPTH-1:0] stk_q;
    logic [CW-1:0]    cnt_q;
    logic             hit;

    // comparison of the broadcast key with the local value
    always_comb begin
        unique case (cmp)
            CMP_EQ:  hit = (val_q == key);
            CMP_LT:  hit = (val_q < key);
            CMP_GT:  hit = (val_q > key);
            default: hit = 1'b0;
        endcase
    end

    // an empty stack leaves the PE enabled
    assign top = (cnt_q == '0) ? 1'b1 : stk_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            stk_q <= '0;
            cnt_q <= '0;
            resp  <= 1'b0;
        end else begin
            if (ld_we) begin
                val_q <= ld_val;
            end
            if (do_search) begin
                if (top) begin
                    resp  <= hit;
                    stk_q <= {stk_q[DEPTH-2:0], hit};
                    if (cnt_q != CW'(DEPTH)) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else if (do_step) begin
                if (is_sel) begin
                    resp <= 1'b0;
                end
                stk_q[0] <= is_sel;
                if (cnt_q == '0) begin
                    cnt_q <= CW'(1);
                end
            end else if (do_pop) begin
                if (cnt_q != '0) begin
                    stk_q <= {1'b0, stk_q[DEPTH-1:1]};
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R4: a disabled PE keeps its responder flag through a search
    a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (do_search && !top) |=> (resp == $past(resp)));

    // R8: the chosen PE ends a step enabled with its flag cleared
    a_r8_step_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && is_sel) |=> (top && !resp));

    // R8: every other PE ends a step disabled
    a_r8_step_other: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && !is_sel) |=> !top);

    // R9: popping an empty stack leaves it empty
    a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && cnt_q == '0) |=> (cnt_q == '0));

    // R10: the stack never holds more than DEPTH entries
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/as_resolver.sv
module as_resolver #(
    parameter int N = 16,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    resp,
    output logic [IDXW-1:0] win_idx,
    output logic            win_found
);

    // lowest set index wins: scan from the top so lower indices overwrite
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (resp[i]) begin
                win_found = 1'b1;
                win_idx   = IDXW'(i);
            end
        end
    end

    logic [N-1:0] below_mask;
    assign below_mask = (N'(1) << win_idx) - N'(1);

    // R5: the winner is a responder with no responder beneath it
    a_r5_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        win_found |-> (resp[win_idx] && ((resp & below_mask) == '0)));

    // R7: no winner is reported for an empty responder set
    a_r7_none: assert property (@(posedge clk) disable iff (!rst_n)
        (resp == '0) |-> !win_found);

endmodule

// File: rtl/as_seq.sv
module as_seq
    import as_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 8,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cmd,
    input  logic [1:0]      cmp_sel,
    input  logic [W-1:0]    key,
    input  logic [IDXW-1:0] win_idx,
    input  logic            win_found,
    output logic            do_search,
    output logic            do_step,
    output logic            do_pop,
    output logic [W-1:0]    bkey,
    output cmp_e            bcmp,
    output logic [IDXW-1:0] sel_idx,
    output logic            sel_valid
);

    state_e state_q;
    state_e state_d;

    always_comb begin
        unique case (cmd_e'(cmd))
            CMD_SEARCH: state_d = ST_SEARCH;
            CMD_STEP:   state_d = ST_STEP;
            CMD_POP:    state_d = ST_POP;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register with the broadcast operands latched beside it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bkey    <= '0;
            bcmp    <= CMP_EQ;
        end else begin
            state_q <= state_d;
            bkey    <= key;
            bcmp    <= cmp_e'(cmp_sel);
        end
    end

    // actions driven by the current state
    always_comb begin
        do_search = 1'b0;
        do_step   = 1'b0;
        do_pop    = 1'b0;
        unique case (state_q)
            ST_SEARCH: do_search = 1'b1;
            ST_STEP:   do_step   = 1'b1;
            ST_POP:    do_pop    = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx   <= '0;
            sel_valid <= 1'b0;
        end else if (do_step) begin
            sel_idx   <= win_found ? win_idx : '0;
            sel_valid <= win_found;
        end
    end

    // R5: a step that found a winner reports it on the next cycle
    a_r5_report: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && win_found) |=> (sel_valid && sel_idx == $past(win_idx)));

    // R7: a step with no responders leaves the valid flag low
    a_r7_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && !win_found) |=> !sel_valid);

    // the selection only moves on a step
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !do_step |=> $stable(sel_valid));

endmodule

// File: rtl/assoc_search_array.sv
module assoc_search_array
    import as_pkg::*;
#(
    parameter int N     = 16,
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [W-1:0]    ld_val,
    input  logic [1:0]      cmd,
    input  logic [1:0]      cmp_sel,
    input  logic [W-1:0]    key,
    output logic [IDXW-1:0] sel_idx,
    output logic            sel_valid,
    output logic            any_resp
);

    logic            do_search;
    logic            do_step;
    logic            do_pop;
    logic [W-1:0]    bkey;
    cmp_e            bcmp;
    logic [IDXW-1:0] win_idx;
    logic            win_found;
    logic [N-1:0]    resp;
    logic [N-1:0]    top;

    as_seq #(.N(N), .W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .cmp_sel   (cmp_sel),
        .key       (key),
        .win_idx   (win_idx),
        .win_found (win_found),
        .do_search (do_search),
        .do_step   (do_step),
        .do_pop    (do_pop),
        .bkey      (bkey),
        .bcmp      (bcmp),
        .sel_idx   (sel_idx),
        .sel_valid (sel_valid)
    );

    as_resolver #(.N(N)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .resp      (resp),
        .win_idx   (win_idx),
        .win_found (win_found)
    );

    for (genvar g = 0; g < N; g++) begin : g_pe
        as_pe #(.W(W), .DEPTH(DEPTH)) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_we     (ld_en && (ld_idx == IDXW'(g))),
            .ld_val    (ld_val),
            .do_search (do_search),
            .do_step   (do_step),
            .do_pop    (do_pop),
            .key       (bkey),
            .cmp       (bcmp),
            .is_sel    (win_found && (win_idx == IDXW'(g))),
            .resp      (resp[g]),
            .top       (top[g])
        );
    end

    assign any_resp = |resp;

    // R8: after a step at most one PE remains enabled
    a_r8_single_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        do_step |=> $onehot0(top));

    // R6: a step with exactly one responder empties the responder set
    a_r6_last_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && $countones(resp) == 1) |=> !any_resp);

endmodule

// File: tb/test_assoc_search_array.sv
module test_assoc_search_array;

    localparam int N    = 16;
    localparam int W    = 8;
    localparam int IDXW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_en = 1'b0;
    logic [IDXW-1:0] ld_idx = '0;
    logic [W-1:0]    ld_val = '0;
    logic [1:0]      cmd = 2'd0;
    logic [1:0]      cmp_sel = 2'd0;
    logic [W-1:0]    key = '0;
    logic [IDXW-1:0] sel_idx;
    logic            sel_valid;
    logic            any_resp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    assoc_search_array #(.N(N), .W(W), .DEPTH(4)) i_assoc_search_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .ld_val    (ld_val),
        .cmd       (cmd),
        .cmp_sel   (cmp_sel),
        .key       (key),
        .sel_idx   (sel_idx),
        .sel_valid (sel_valid),
        .any_resp  (any_resp)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input int v);
        @(negedge clk);
        ld_en  = 1'b1;
        ld_idx = IDXW'(idx);
        ld_val = W'(v);
        @(negedge clk);
        ld_en  = 1'b0;
    endtask

    // apply a command, then wait until two edges have passed
    task automatic issue(input int c, input int op, input int k);
        @(negedge clk);
        cmd     = 2'(c);
        cmp_sel = 2'(op);
        key     = W'(k);
        @(negedge clk);
        cmd     = 2'd0;
        @(negedge clk);
    endtask

    task automatic search(input int op, input int k);
        issue(1, op, k);
    endtask

    task automatic step();
        issue(2, 0, 0);
    endtask

    task automatic pop();
        issue(3, 0, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) pop();
    endtask

    task automatic t_reset();
        chk("R1 sel_valid", int'(sel_valid), 0);
        chk("R1 sel_idx", int'(sel_idx), 0);
        chk("R1 any_resp", int'(any_resp), 0);
    endtask

    task automatic t_step_empty();
        step();
        chk("R7 step without responders", int'(sel_valid), 0);
    endtask

    task automatic t_equal();
        drain();
        search(0, 8'h77);
        chk("R2 equal search any_resp", int'(any_resp), 1);
        step();
        chk("R5 first valid", int'(sel_valid), 1);
        chk("R5 first index", int'(sel_idx), 3);
        chk("R6 responder left", int'(any_resp), 1);
        step();
        chk("R6 second index", int'(sel_idx), 9);
        chk("R6 any_resp after last", int'(any_resp), 0);
        step();
        chk("R7 step after last", int'(sel_valid), 0);
    endtask

    task automatic t_relational();
        drain();
        search(1, 30);
        chk("R3 less any_resp", int'(any_resp), 1);
        step();
        chk("R3 less lowest", int'(sel_idx), 0);
        step();
        chk("R3 less next", int'(sel_idx), 1);
        drain();
        load(5, 200);
        search(2, 140);
        step();
        chk("R3 greater unsigned", int'(sel_idx), 5);
        step();
        chk("R3 greater next", int'(sel_idx), 15);
        chk("R6 greater drained", int'(any_resp), 0);
        drain();
        search(3, 0);
        chk("R3 code 3 matches none", int'(any_resp), 0);
    endtask

    task automatic t_disabled();
        drain();
        search(0, 8'h77);
        step();
        chk("R8 first pick", int'(sel_idx), 3);
        // only PE3 is enabled; PE0 holds 0 but must not respond
        search(0, 0);
        chk("R4 disabled flag kept", int'(any_resp), 1);
        step();
        chk("R4 disabled PE ignored search", int'(sel_idx), 9);
        chk("R8 valid", int'(sel_valid), 1);
    endtask

    task automatic t_pop();
        drain();
        search(0, 8'h77);
        search(0, 0);
        chk("R9 nested search empty", int'(any_resp), 0);
        pop();
        search(0, 8'h77);
        chk("R9 pop re-enables", int'(any_resp), 1);
        step();
        chk("R9 pick after pop", int'(sel_idx), 3);
        drain();
        pop();
        pop();
        search(0, 0);
        step();
        chk("R9 empty pop ignored", int'(sel_idx), 0);
        chk("R9 empty pop valid", int'(sel_valid), 1);
    endtask

    task automatic t_depth();
        drain();
        for (int i = 0; i < 5; i++) search(0, 8'h77);
        step();
        chk("R10 pick", int'(sel_idx), 3);
        pop();
        search(0, 8'h77);
        step();
        chk("R10 entry beneath exposed first", int'(sel_idx), 3);
        step();
        chk("R10 entry beneath exposed second", int'(sel_idx), 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_step_empty();
        for (int i = 0; i < N; i++) load(i, i * 10);
        load(3, 8'h77);
        load(9, 8'h77);
        t_equal();
        t_relational();
        t_disabled();
        t_pop();
        t_depth();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule